// File: doc/BRIEF.md
# Serial Link Status Flag Logic

This block holds the four status flags of a serial data link controller: message transmitted, message received, header received and break received. It has no view of the bus itself. The link engine sends it single-cycle event strobes (frame sent with arbitration won, end of frame, header complete, break symbol, byte sent, byte received). The FIFO supplies pointer-compare levels. The CPU side supplies buffer access strobes and software reset and clear bits. The block turns these into a status word that the CPU can read.

Two operating modes change the rules for the transmit and receive flags. In frame mode the flags follow whole-frame events. In stream mode the flags follow FIFO pointer comparisons and CPU buffer accesses. The header and break flags behave the same way in both modes. The mode input is sampled every cycle. All flags are registered, so an event applied in one cycle shows in the status word after the next rising clock edge. Reset is asynchronous active-low and is released through a synchronizer.

Top module: `link_status_flags`

## Requirements
- R1: While reset is low, and after it is released, the status word is all zeros. Bits 15 down to 4 always read zero.
- R2: In frame mode (`blk_mode`=0), bit 0 sets after `ev_frame_sent` and clears only on `sw_tx_rst`. `cpu_tx_wr`, `ev_eof` and byte events leave it unchanged.
- R3: In stream mode (`blk_mode`=1), bit 0 sets after `ev_byte_tx` while `tx_ptr_eq`=1, or after `ev_eof`. It clears on `cpu_tx_wr` or `sw_tx_rst`. `ev_frame_sent` has no effect on it.
- R4: In frame mode, bit 1 sets after `ev_eof` and clears on `sw_rx_rst` or `rx_buf_ovw`. `cpu_rx_rd` has no effect on it.
- R5: In stream mode, bit 1 sets after `ev_byte_rx` while `rx_ptr_eq`=0 (FIFO not empty), or after `ev_eof`. It clears on `cpu_rx_rd` or `sw_rx_rst`. `rx_buf_ovw` has no effect on it.
- R6: Bit 2 sets after `ev_hdr_done` and clears after `ev_eof`, in either mode.
- R7: Bit 3 sets after `ev_break` and clears only on `sw_brk_clr`.
- R8: When a set condition and a clear condition for the same flag fall in the same cycle, the flag ends up set.
- R9: Changing `blk_mode` does not by itself change any flag that is already set.
- R10: Each flag changes on the rising clock edge that samples its set or clear condition, so it is visible one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_mode | input | 1 | 0 = frame mode, 1 = stream mode |
| ev_frame_sent | input | 1 | Whole transmit frame sent, arbitration won, end of data seen |
| ev_eof | input | 1 | End of frame detected |
| ev_hdr_done | input | 1 | All header bytes received |
| ev_break | input | 1 | Break symbol detected |
| ev_byte_tx | input | 1 | One byte transmitted |
| ev_byte_rx | input | 1 | One byte received |
| tx_ptr_eq | input | 1 | Transmit FIFO pointers equal |
| rx_ptr_eq | input | 1 | Receive FIFO pointers equal |
| cpu_tx_wr | input | 1 | CPU write to transmit buffer |
| cpu_rx_rd | input | 1 | CPU read of receive buffer |
| sw_tx_rst | input | 1 | Software transmit reset |
| sw_rx_rst | input | 1 | Software receive reset |
| sw_brk_clr | input | 1 | Software clear of the break flag |
| rx_buf_ovw | input | 1 | Bus-side receive buffer overwritten |
| status | output | 16 | Status word: bit0 transmitted, bit1 received, bit2 header, bit3 break |

## Verification
Several collisions can fall in one cycle. A set and a clear can hit the same flag. End of frame can both clear the header flag and set the received flag. A mode change can coincide with a strobe that only one mode honours. Directed pulses provoke each of these deliberately, for example a CPU buffer write together with a pointer-match byte, a break together with its clear, or end of frame together with a receive reset. A long random phase then mixes all strobes and flips the mode. A behavioural model in the bench judges every cycle, and each directed pulse is also compared against a fixed expected word.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  localparam int FLAG_CNT = 4;
  localparam int BIT_TXD  = 0;
  localparam int BIT_RXD  = 1;
  localparam int BIT_HDR  = 2;
  localparam int BIT_BRK  = 3;

  typedef enum logic {
    MODE_FRAME  = 1'b0,
    MODE_STREAM = 1'b1
  } link_mode_e;

  typedef struct packed {
    logic set;
    logic clr;
  } flag_ctl_t;
endpackage

// File: rtl/lsf_rst_sync.sv
module lsf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/lsf_flag_cell.sv
module lsf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_r;
  logic q_d;
  logic q_en;

  // set has priority so that no event is dropped
  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= 1'b0;
    else if (q_en) q_r <= q_d;
  end

  assign q_o = q_r;

  assert_set_dominates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/lsf_tx_rules.sv
module lsf_tx_rules
  import lsf_pkg::*;
(
  input  link_mode_e mode,
  input  logic       frame_sent,
  input  logic       eof,
  input  logic       byte_sent,
  input  logic       ptr_match,
  input  logic       cpu_wr,
  input  logic       sw_rst,
  output flag_ctl_t  ctl
);
  always_comb begin
    ctl = '0;
    case (mode)
      MODE_FRAME: begin
        ctl.set = frame_sent;
        ctl.clr = sw_rst;
      end
      MODE_STREAM: begin
        ctl.set = (byte_sent & ptr_match) | eof;
        ctl.clr = sw_rst | cpu_wr;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/lsf_rx_rules.sv
module lsf_rx_rules
  import lsf_pkg::*;
(
  input  link_mode_e mode,
  input  logic       eof,
  input  logic       byte_rcvd,
  input  logic       ptr_equal,
  input  logic       cpu_rd,
  input  logic       buf_ovw,
  input  logic       sw_rst,
  output flag_ctl_t  ctl
);
  always_comb begin
    ctl = '0;
    case (mode)
      MODE_FRAME: begin
        ctl.set = eof;
        ctl.clr = sw_rst | buf_ovw;
      end
      MODE_STREAM: begin
        ctl.set = (byte_rcvd & ~ptr_equal) | eof;
        ctl.clr = sw_rst | cpu_rd;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/lsf_aux_rules.sv
module lsf_aux_rules
  import lsf_pkg::*;
(
  input  logic      hdr_done,
  input  logic      eof,
  input  logic      brk_seen,
  input  logic      brk_clr,
  output flag_ctl_t hdr_ctl,
  output flag_ctl_t brk_ctl
);
  always_comb begin
    hdr_ctl.set = hdr_done;
    hdr_ctl.clr = eof;
    brk_ctl.set = brk_seen;
    brk_ctl.clr = brk_clr;
  end
endmodule

// File: rtl/link_status_flags.sv
module link_status_flags
  import lsf_pkg::*;
#(
  parameter int STAT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_mode,
  input  logic              ev_frame_sent,
  input  logic              ev_eof,
  input  logic              ev_hdr_done,
  input  logic              ev_break,
  input  logic              ev_byte_tx,
  input  logic              ev_byte_rx,
  input  logic              tx_ptr_eq,
  input  logic              rx_ptr_eq,
  input  logic              cpu_tx_wr,
  input  logic              cpu_rx_rd,
  input  logic              sw_tx_rst,
  input  logic              sw_rx_rst,
  input  logic              sw_brk_clr,
  input  logic              rx_buf_ovw,
  output logic [STAT_W-1:0] status
);
  localparam int PAD_W = STAT_W - FLAG_CNT;

  logic       rst_q_n;
  link_mode_e mode;
  flag_ctl_t  tx_ctl, rx_ctl, hdr_ctl, brk_ctl;
  logic [FLAG_CNT-1:0] set_vec;
  logic [FLAG_CNT-1:0] clr_vec;
  logic [FLAG_CNT-1:0] flags;

  lsf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign mode = link_mode_e'(blk_mode);

  lsf_tx_rules u_tx (
    .mode(mode), .frame_sent(ev_frame_sent), .eof(ev_eof),
    .byte_sent(ev_byte_tx), .ptr_match(tx_ptr_eq), .cpu_wr(cpu_tx_wr),
    .sw_rst(sw_tx_rst), .ctl(tx_ctl));

  lsf_rx_rules u_rx (
    .mode(mode), .eof(ev_eof), .byte_rcvd(ev_byte_rx), .ptr_equal(rx_ptr_eq),
    .cpu_rd(cpu_rx_rd), .buf_ovw(rx_buf_ovw), .sw_rst(sw_rx_rst),
    .ctl(rx_ctl));

  lsf_aux_rules u_aux (
    .hdr_done(ev_hdr_done), .eof(ev_eof), .brk_seen(ev_break),
    .brk_clr(sw_brk_clr), .hdr_ctl(hdr_ctl), .brk_ctl(brk_ctl));

  always_comb begin
    set_vec          = '0;
    clr_vec          = '0;
    set_vec[BIT_TXD] = tx_ctl.set;
    clr_vec[BIT_TXD] = tx_ctl.clr;
    set_vec[BIT_RXD] = rx_ctl.set;
    clr_vec[BIT_RXD] = rx_ctl.clr;
    set_vec[BIT_HDR] = hdr_ctl.set;
    clr_vec[BIT_HDR] = hdr_ctl.clr;
    set_vec[BIT_BRK] = brk_ctl.set;
    clr_vec[BIT_BRK] = brk_ctl.clr;
  end

  for (genvar g = 0; g < FLAG_CNT; g++) begin : g_flag
    lsf_flag_cell u_cell (
      .clk(clk), .rst_n(rst_q_n),
      .set_i(set_vec[g]), .clr_i(clr_vec[g]), .q_o(flags[g]));
  end

  if (PAD_W > 0) begin : g_pad
    assign status = {{PAD_W{1'b0}}, flags};
  end else begin : g_nopad
    assign status = flags[STAT_W-1:0];
  end

  assert_brk_needs_event_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(status[BIT_BRK]) |-> $past(ev_break));
  assert_brk_sticky_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (status[BIT_BRK] && !sw_brk_clr) |=> status[BIT_BRK]);
  assert_hdr_clear_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ev_eof && !ev_hdr_done) |=> !status[BIT_HDR]);
  assert_tx_frame_hold_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!blk_mode && status[BIT_TXD] && !sw_tx_rst) |=> status[BIT_TXD]);
  assert_rx_stream_read_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (blk_mode && cpu_rx_rd && !ev_eof && !(ev_byte_rx && !rx_ptr_eq)) |=> !status[BIT_RXD]);
  assert_rx_frame_eof_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!blk_mode && ev_eof) |=> status[BIT_RXD]);
endmodule

// File: tb/link_status_flags_test.sv
`timescale 1ns/1ps
module link_status_flags_test;
  localparam int EVN = 14;
  // event vector bit positions
  localparam int E_FS = 0, E_EOF = 1, E_HDR = 2, E_BRK = 3, E_BTX = 4, E_BRX = 5,
                 E_TEQ = 6, E_REQ = 7, E_WR = 8, E_RD = 9, E_TRS = 10, E_RRS = 11,
                 E_BCL = 12, E_OVW = 13;

  logic clk = 1'b0;
  logic rst_n;
  logic mode;
  logic [EVN-1:0] ev;
  logic [15:0] status;
  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;
  bit m_tx, m_rx, m_hdr, m_brk;

  always #2.5 clk = ~clk;

  link_status_flags uut (
    .clk(clk), .rst_n(rst_n), .blk_mode(mode),
    .ev_frame_sent(ev[E_FS]), .ev_eof(ev[E_EOF]), .ev_hdr_done(ev[E_HDR]),
    .ev_break(ev[E_BRK]), .ev_byte_tx(ev[E_BTX]), .ev_byte_rx(ev[E_BRX]),
    .tx_ptr_eq(ev[E_TEQ]), .rx_ptr_eq(ev[E_REQ]), .cpu_tx_wr(ev[E_WR]),
    .cpu_rx_rd(ev[E_RD]), .sw_tx_rst(ev[E_TRS]), .sw_rx_rst(ev[E_RRS]),
    .sw_brk_clr(ev[E_BCL]), .rx_buf_ovw(ev[E_OVW]), .status(status));

  // behavioural reference: each flag decides set, then clear, then hold
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx <= 0; m_rx <= 0; m_hdr <= 0; m_brk <= 0;
    end else begin
      bit s, c;
      if (mode) begin
        s = (ev[E_BTX] && ev[E_TEQ]) || ev[E_EOF];
        c = ev[E_WR] || ev[E_TRS];
      end else begin
        s = ev[E_FS];
        c = ev[E_TRS];
      end
      if (s) m_tx <= 1; else if (c) m_tx <= 0;
      if (mode) begin
        s = (ev[E_BRX] && !ev[E_REQ]) || ev[E_EOF];
        c = ev[E_RD] || ev[E_RRS];
      end else begin
        s = ev[E_EOF];
        c = ev[E_RRS] || ev[E_OVW];
      end
      if (s) m_rx <= 1; else if (c) m_rx <= 0;
      if (ev[E_HDR]) m_hdr <= 1; else if (ev[E_EOF]) m_hdr <= 0;
      if (ev[E_BRK]) m_brk <= 1; else if (ev[E_BCL]) m_brk <= 0;
    end
  end

  function automatic string bit_tag(int b);
    case (b)
      0: return mode ? "R3" : "R2";
      1: return mode ? "R5" : "R4";
      2: return "R6";
      3: return "R7";
      default: return "R1";
    endcase
  endfunction

  // per-cycle comparison against the model (R10 timing)
  always @(negedge clk) begin
    if (cmp_en) begin
      logic [15:0] want;
      want = {12'h000, m_brk, m_hdr, m_rx, m_tx};
      checks++;
      if (status !== want) begin
        errors++;
        for (int b = 0; b < 16; b++)
          if (status[b] !== want[b]) begin
            $display("FAIL %s R10 cycle compare bit %0d: actual %h expected %h",
                     bit_tag(b), b, status, want);
            break;
          end
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] want);
    checks++;
    if (status !== want) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, status, want);
    end
  endtask

  task automatic pulse(input logic [EVN-1:0] v, input logic [15:0] want, input string tag);
    @(negedge clk) ev = v;
    @(negedge clk) ev = '0;
    #1 check(tag, want);
  endtask

  function automatic logic [EVN-1:0] e(input int a, input int b = -1, input int c = -1);
    logic [EVN-1:0] r = '0;
    r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 1'b0; ev = '0;
    repeat (4) @(negedge clk);
    check("R1 in reset", 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1;
    #1 check("R1 after release", 16'h0000);

    // frame mode
    pulse(e(E_FS), 16'h0001, "R2 frame sent sets");
    pulse(e(E_WR, E_EOF), 16'h0003, "R2 write ignored / R4 eof sets");
    pulse(e(E_BTX, E_TEQ), 16'h0003, "R2 byte ignored");
    pulse(e(E_TRS), 16'h0002, "R2 tx reset clears");
    pulse(e(E_RD), 16'h0002, "R4 cpu read ignored");
    pulse(e(E_OVW), 16'h0000, "R4 overwrite clears");
    pulse(e(E_HDR), 16'h0004, "R6 header sets");
    pulse(e(E_EOF), 16'h0002, "R6 eof clears header");
    pulse(e(E_RRS, E_EOF), 16'h0002, "R8 rx set beats reset");
    pulse(e(E_RRS), 16'h0000, "R4 rx reset clears");
    pulse(e(E_BRK), 16'h0008, "R7 break sets");
    pulse(e(E_TRS, E_RRS, E_OVW), 16'h0008, "R7 other resets ignored");
    pulse(e(E_BRK, E_BCL), 16'h0008, "R8 break beats clear");
    pulse(e(E_BCL), 16'h0000, "R7 clear removes break");
    pulse(e(E_HDR, E_EOF), 16'h0006, "R8 header set beats eof clear");
    pulse(e(E_RRS), 16'h0004, "R4 rx reset");
    pulse(e(E_EOF), 16'h0002, "R6 header cleared");
    pulse(e(E_RRS), 16'h0000, "R4 rx reset");

    // stream mode
    @(negedge clk) mode = 1'b1;
    pulse(e(E_BTX), 16'h0000, "R3 byte without match");
    pulse(e(E_BTX, E_TEQ), 16'h0001, "R3 byte with match sets");
    pulse(e(E_WR), 16'h0000, "R3 write clears");
    pulse(e(E_FS), 16'h0000, "R3 frame sent ignored");
    pulse(e(E_BRX, E_REQ), 16'h0000, "R5 byte with fifo empty");
    pulse(e(E_BRX), 16'h0002, "R5 byte with fifo not empty");
    pulse(e(E_OVW), 16'h0002, "R5 overwrite ignored");
    pulse(e(E_RD), 16'h0000, "R5 read clears");
    pulse(e(E_EOF), 16'h0003, "R3 R5 eof sets both");
    @(negedge clk) mode = 1'b0;
    #1 check("R9 mode change keeps flags", 16'h0003);
    pulse(e(E_WR, E_RD), 16'h0003, "R2 R4 stream clears ignored in frame mode");
    pulse(e(E_TRS, E_RRS), 16'h0000, "R2 R4 resets");
    @(negedge clk) mode = 1'b1;
    pulse(e(E_WR, E_BTX, E_TEQ), 16'h0001, "R8 write loses to match");
    pulse(e(E_RD, E_BRX), 16'h0003, "R8 read loses to byte");
    pulse(e(E_TRS, E_RRS), 16'h0000, "R3 R5 resets");

    // random mix with mode flips, judged by the model each cycle
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      for (int b = 0; b < EVN; b++) ev[b] = ($urandom % 6) == 0;
      if (($urandom % 40) == 0) mode = ~mode;
    end
    @(negedge clk) ev = '0;
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule